// File: doc/BRIEF.md
# Three-Wire Serial Memory Slave

This block models the slave side of a three-wire serial memory. Its pins are a select line, a serial clock, serial data in and serial data out. The data out pin comes with an output-enable that stands in for a tri-state driver. A small register array, parameterised in address and word width, stands in for the nonvolatile cells. All three serial pins are synchronised into the system clock, and the serial clock is edge-detected there. Every decision is made on rising edges of the serial clock as seen in the system clock domain.

A transfer begins while the block is selected. The master sends a start bit of 1, then a two-bit command code, then the address, most significant bit first. Reads return a dummy zero and then the stored word. Writes and write-all take a data word, and are held until the master drops select. At that point a self-timed programming cycle runs for a fixed number of system clocks, with no serial clocks needed. A write-protect latch comes up disabled at reset and gates every programming request. While a cycle is in progress, reselecting the block puts the busy/ready flag on the data out pin.

Top module: `mw_eeprom_slave`

## Requirements
- R1: `sdout_en` is low in standby, and it is low again no later than four system clocks after `sel` is sampled low.
- R2: Zeros shifted in ahead of the start bit are ignored. An instruction is a 1, then a two-bit code, then ADDR_W address bits sent MSB first, all sampled on rising `sclk`.
- R3: Code 10 reads. After the last address bit, `sdout` is driven to 0, the dummy bit. Each later rising `sclk` then presents the next bit of the addressed word, MSB first.
- R4: Code 01 writes. DATA_W data bits follow MSB first. Once `sel` drops, the word is programmed into the addressed cell, and no other cell changes.
- R5: After reset the write-protect latch is disabled. Programming requests are then dropped, with no busy cycle and no change to the array. Code 00 with the top two address bits 11 enables the latch. Code 00 with the top two address bits 00 disables it again. The remaining address bits are don't-care.
- R6: Code 00 with the top two address bits 01 writes all. The data word that follows goes into every cell, whatever the cells held before.
- R7: Reselecting during a programming cycle drives `sdout_en` high and `sdout` to 0. Once the cycle completes, `sdout` turns to 1.
- R8: The programming cycle starts when `sel` drops. It lasts PROG_CYCLES system clocks, with no `sclk` activity.
- R9: If `sel` drops before the instruction and all its data bits have arrived, nothing is programmed and no busy cycle starts.
- R10: Reads return the same stored data whether the write-protect latch is enabled or disabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Active-low reset, which also models power-up |
| sel | input | 1 | Select, active high |
| sclk | input | 1 | Serial clock from the master |
| sdin | input | 1 | Serial data into the block |
| sdout | output | 1 | Serial data out: read data or the busy/ready flag |
| sdout_en | output | 1 | Drive enable for `sdout`; low means high-impedance |

## Verification
Reads are tried at several addresses, both with and without leading zeros before the start bit. This separates a correct start-bit search from one that treats the first clock as the start. Writes are issued three ways: with the latch disabled, with it enabled, and cut short by an early deselect. Each outcome is then read back at the target cell and at a neighbour, which separates protection, programming and abort. The busy flag is polled both shortly before and after the nominal cycle end, which pins the cycle length from both sides. A write-all followed by reads at both ends of the array shows that every cell was reached.

// File: rtl/mw_pkg.sv
package mw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_HDR, ST_DATA, ST_READ, ST_ARMED, ST_DONE, ST_STATUS
  } mw_state_e;

  localparam logic [1:0] OPC_READ  = 2'b10;
  localparam logic [1:0] OPC_WRITE = 2'b01;
  localparam logic [1:0] OPC_EXT   = 2'b00;

  localparam logic [1:0] EXT_EWDS = 2'b00;
  localparam logic [1:0] EXT_WRAL = 2'b01;
  localparam logic [1:0] EXT_EWEN = 2'b11;

  // bits after the start bit: code plus address
  function automatic int hdr_width(input int aw);
    return 2 + aw;
  endfunction

  // read position 0 is the dummy bit, 1..dw are data bits MSB first
  function automatic int read_bit_index(input int dw, input int pos);
    return dw - pos;
  endfunction

endpackage

// File: rtl/mw_sync.sv
module mw_sync #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic [N-1:0] q
);
  logic [N-1:0] meta;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta[i] <= 1'b0;
        q[i]    <= 1'b0;
      end else begin
        meta[i] <= din[i];
        q[i]    <= meta[i];
      end
    end
  end
endmodule

// File: rtl/mw_cmd_fsm.sv
module mw_cmd_fsm
  import mw_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_s,
  input  logic              sk_s,
  input  logic              di_s,
  input  logic              busy,
  input  logic [DATA_W-1:0] rd_word,
  output logic              sk_rise,
  output logic              do_o,
  output logic              do_oe,
  output logic              wen,
  output logic              prog_start,
  output logic              prog_all,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] data_q
);
  localparam int HDR_W = hdr_width(ADDR_W);
  localparam int MAXN  = (HDR_W > DATA_W) ? HDR_W : DATA_W;
  localparam int CNT_W = $clog2(MAXN + 1);
  localparam int POS_W = $clog2(DATA_W + 2);
  localparam int IDX_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] HDR_LAST  = CNT_W'(HDR_W - 1);
  localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);
  localparam logic [POS_W-1:0] POS_END   = POS_W'(DATA_W + 1);

  mw_state_e         state;
  logic              sk_q;
  logic [CNT_W-1:0]  cnt;
  logic [POS_W-1:0]  rd_pos;
  logic [HDR_W-1:0]  hdr_q, hdr_n;
  logic [1:0]        opc_n, ext_n;
  logic [IDX_W-1:0]  bit_sel;

  assign sk_rise = sk_s & ~sk_q;
  assign hdr_n   = {hdr_q[HDR_W-2:0], di_s};
  assign opc_n   = hdr_n[HDR_W-1 -: 2];
  assign ext_n   = hdr_n[ADDR_W-1 -: 2];
  assign bit_sel = IDX_W'(read_bit_index(DATA_W, int'(rd_pos)));

  always_comb begin
    do_oe = (state == ST_READ) || (state == ST_STATUS);
    do_o  = 1'b0;
    if (state == ST_STATUS) begin
      do_o = ~busy;
    end else if (state == ST_READ && rd_pos != '0 && rd_pos != POS_END) begin
      do_o = rd_word[bit_sel];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      sk_q       <= 1'b0;
      cnt        <= '0;
      rd_pos     <= '0;
      hdr_q      <= '0;
      addr_q     <= '0;
      data_q     <= '0;
      wen        <= 1'b0;
      prog_start <= 1'b0;
      prog_all   <= 1'b0;
    end else begin
      sk_q       <= sk_s;
      prog_start <= 1'b0;
      if (!cs_s) begin
        if (state == ST_ARMED && wen) prog_start <= 1'b1;
        state <= ST_IDLE;
      end else begin
        case (state)
          ST_IDLE: state <= busy ? ST_STATUS : ST_START;
          ST_START: begin
            if (sk_rise && di_s) begin
              state <= ST_HDR;
              cnt   <= '0;
            end
          end
          ST_HDR: begin
            if (sk_rise) begin
              hdr_q <= hdr_n;
              cnt   <= cnt + 1'b1;
              if (cnt == HDR_LAST) begin
                addr_q <= hdr_n[ADDR_W-1:0];
                cnt    <= '0;
                rd_pos <= '0;
                case (opc_n)
                  OPC_READ: state <= ST_READ;
                  OPC_WRITE: begin
                    prog_all <= 1'b0;
                    state    <= ST_DATA;
                  end
                  OPC_EXT: begin
                    case (ext_n)
                      EXT_EWEN: begin
                        wen   <= 1'b1;
                        state <= ST_DONE;
                      end
                      EXT_EWDS: begin
                        wen   <= 1'b0;
                        state <= ST_DONE;
                      end
                      EXT_WRAL: begin
                        prog_all <= 1'b1;
                        state    <= ST_DATA;
                      end
                      default: state <= ST_DONE;
                    endcase
                  end
                  default: state <= ST_DONE;
                endcase
              end
            end
          end
          ST_DATA: begin
            if (sk_rise) begin
              data_q <= {data_q[DATA_W-2:0], di_s};
              cnt    <= cnt + 1'b1;
              if (cnt == DATA_LAST) state <= ST_ARMED;
            end
          end
          ST_READ: begin
            if (sk_rise && rd_pos != POS_END) rd_pos <= rd_pos + 1'b1;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/mw_prog_engine.sv
module mw_prog_engine #(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 16,
  parameter int PROG_CYCLES = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              all,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_word,
  output logic              busy,
  output logic              done
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int CW    = $clog2(PROG_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(PROG_CYCLES - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [CW-1:0]     cnt;
  logic              all_l;
  logic [ADDR_W-1:0] addr_l;
  logic [DATA_W-1:0] data_l;

  assign rd_word = mem[rd_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      cnt    <= '0;
      all_l  <= 1'b0;
      addr_l <= '0;
      data_l <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        busy   <= 1'b1;
        cnt    <= '0;
        all_l  <= all;
        addr_l <= addr;
        data_l <= data;
      end else if (busy) begin
        if (cnt == LAST) begin
          busy <= 1'b0;
          done <= 1'b1;
          for (int i = 0; i < DEPTH; i++) begin
            if (all_l || ADDR_W'(i) == addr_l) mem[i] <= data_l;
          end
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/mw_eeprom_slave.sv
module mw_eeprom_slave #(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 16,
  parameter int PROG_CYCLES = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel,
  input  logic sclk,
  input  logic sdin,
  output logic sdout,
  output logic sdout_en
);
  logic [2:0]        pins_s;
  logic              cs_s, sk_s, di_s;
  logic              sk_rise;
  logic              wen_q;
  logic              prog_start, prog_all, prog_busy, prog_done;
  logic [ADDR_W-1:0] cmd_addr;
  logic [DATA_W-1:0] cmd_data, rd_word;

  mw_sync #(.N(3)) u_sync (
    .clk(clk), .rst_n(rst_n), .din({sel, sclk, sdin}), .q(pins_s)
  );
  assign cs_s = pins_s[2];
  assign sk_s = pins_s[1];
  assign di_s = pins_s[0];

  mw_cmd_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .sk_s(sk_s), .di_s(di_s),
    .busy(prog_busy), .rd_word(rd_word), .sk_rise(sk_rise),
    .do_o(sdout), .do_oe(sdout_en), .wen(wen_q),
    .prog_start(prog_start), .prog_all(prog_all),
    .addr_q(cmd_addr), .data_q(cmd_data)
  );

  mw_prog_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PROG_CYCLES(PROG_CYCLES)) u_prog (
    .clk(clk), .rst_n(rst_n), .start(prog_start), .all(prog_all),
    .addr(cmd_addr), .data(cmd_data), .rd_addr(cmd_addr),
    .rd_word(rd_word), .busy(prog_busy), .done(prog_done)
  );
endmodule

// File: rtl/mw_eeprom_slave_chk.sv
module mw_eeprom_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic sel,
  input logic sdout,
  input logic sdout_en,
  input logic cs_s,
  input logic sk_rise,
  input logic wen_q,
  input logic prog_start,
  input logic prog_busy,
  input logic prog_done
);
  a_r1_hiz_after_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel && !$past(sel) && !$past(sel, 2) && !$past(sel, 3)) |-> !sdout_en);

  a_r5_start_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |-> wen_q);

  a_r5_latch_moves_when_selected: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wen_q) |-> ($past(cs_s) && $past(sk_rise)));

  a_r4_start_after_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |-> $past(!cs_s));

  a_r8_start_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |=> prog_busy);

  a_r8_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    prog_done |-> (!prog_busy && $past(prog_busy)));

  a_r7_busy_shows_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (sdout_en && prog_busy) |-> !sdout);
endmodule

bind mw_eeprom_slave mw_eeprom_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sel(sel), .sdout(sdout), .sdout_en(sdout_en),
  .cs_s(cs_s), .sk_rise(sk_rise), .wen_q(wen_q), .prog_start(prog_start),
  .prog_busy(prog_busy), .prog_done(prog_done)
);

// File: tb/mw_eeprom_slave_tb.sv
module mw_eeprom_slave_tb;
  localparam int AW = 6;
  localparam int DW = 16;
  localparam int PC = 200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel = 1'b0, sclk = 1'b0, sdin = 1'b0;
  logic sdout, sdout_en;

  int checks = 0;
  int errors = 0;

  logic [DW-1:0] exp_q[$];
  string         tag_q[$];
  logic [DW-1:0] obs_word;
  event          rd_ev;

  always #2 clk = ~clk;

  mw_eeprom_slave #(.ADDR_W(AW), .DATA_W(DW), .PROG_CYCLES(PC)) u_dut (
    .clk(clk), .rst_n(rst_n), .sel(sel), .sclk(sclk), .sdin(sdin),
    .sdout(sdout), .sdout_en(sdout_en)
  );

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(rd_ev);
      if (exp_q.size() == 0) begin
        check(1'b0, "SCOREBOARD", {16'h0, obs_word}, 32'h0);
      end else begin
        logic [DW-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(obs_word == e, t, {16'h0, obs_word}, {16'h0, e});
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  task automatic sk_bit(input logic b);
    sdin = b;
    repeat (8) @(negedge clk);
    sclk = 1'b1;
    repeat (8) @(negedge clk);
    sclk = 1'b0;
  endtask

  task automatic sel_on();
    sel = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic sel_off();
    sel = 1'b0;
    sdin = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic send_hdr(input logic [1:0] opc, input logic [AW-1:0] addr);
    sk_bit(1'b1);
    sk_bit(opc[1]);
    sk_bit(opc[0]);
    for (int i = AW - 1; i >= 0; i--) sk_bit(addr[i]);
  endtask

  task automatic send_word(input logic [DW-1:0] w, input int nbits);
    for (int i = DW - 1; i >= DW - nbits; i--) sk_bit(w[i]);
  endtask

  task automatic do_read(input logic [AW-1:0] addr, input logic [DW-1:0] exp,
                         input string tag, input int lead);
    logic [DW-1:0] w;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    sel_on();
    for (int i = 0; i < lead; i++) sk_bit(1'b0);
    send_hdr(2'b10, addr);
    repeat (4) @(negedge clk);
    check(sdout_en === 1'b1 && sdout === 1'b0, "R3 dummy", {30'h0, sdout_en, sdout}, 32'h2);
    w = '0;
    for (int i = 0; i < DW; i++) begin
      sk_bit(1'b0);
      w = {w[DW-2:0], sdout};
    end
    sel_off();
    check(sdout_en === 1'b0, "R1 release", {31'h0, sdout_en}, 32'h0);
    obs_word = w;
    ->rd_ev;
    @(negedge clk);
  endtask

  task automatic do_write(input logic [AW-1:0] addr, input logic [DW-1:0] d);
    sel_on();
    send_hdr(2'b01, addr);
    send_word(d, DW);
    sel_off();
  endtask

  task automatic do_ext(input logic [1:0] code, input logic [DW-1:0] d, input int nbits);
    sel_on();
    send_hdr(2'b00, {code, {(AW-2){1'b0}}});
    if (nbits > 0) send_word(d, nbits);
    sel_off();
  endtask

  task automatic expect_idle(input string tag);
    sel_on();
    check(sdout_en === 1'b0, tag, {31'h0, sdout_en}, 32'h0);
    sel_off();
  endtask

  task automatic wait_ready(input string tag);
    sel_on();
    check(sdout_en === 1'b1 && sdout === 1'b0, tag, {30'h0, sdout_en, sdout}, 32'h2);
    repeat (PC + 20) @(negedge clk);
    check(sdout === 1'b1, tag, {31'h0, sdout}, 32'h1);
    sel_off();
  endtask

  initial begin
    repeat (10) @(negedge clk);
    check(sdout_en === 1'b0, "R1 reset", {31'h0, sdout_en}, 32'h0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(sdout_en === 1'b0, "R1 standby", {31'h0, sdout_en}, 32'h0);

    // R2 and R3: plain read and read with leading zeros
    do_read(6'd5, 16'hFFFF, "R3 read", 0);
    do_read(6'd9, 16'hFFFF, "R2 lead zeros", 2);

    // R5: write while protected is dropped
    do_write(6'd5, 16'hA5C3);
    expect_idle("R5 no busy when protected");
    do_read(6'd5, 16'hFFFF, "R5 cell unchanged", 0);

    // enable, read still works (R10)
    do_ext(2'b11, '0, 0);
    do_read(6'd5, 16'hFFFF, "R10 read enabled", 0);

    // R4, R7, R8: programmed write with status polling
    do_write(6'd5, 16'hA5C3);
    sel_on();
    check(sdout_en === 1'b1 && sdout === 1'b0, "R7 busy", {30'h0, sdout_en, sdout}, 32'h2);
    repeat (PC - 40) @(negedge clk);
    check(sdout === 1'b0, "R8 still busy", {31'h0, sdout}, 32'h0);
    repeat (60) @(negedge clk);
    check(sdout === 1'b1, "R8 ready after cycle", {31'h0, sdout}, 32'h1);
    sel_off();
    do_read(6'd5, 16'hA5C3, "R4 written", 0);
    do_read(6'd4, 16'hFFFF, "R4 neighbour", 0);

    // R9: aborted write
    sel_on();
    send_hdr(2'b01, 6'd7);
    send_word(16'h1234, 8);
    sel_off();
    expect_idle("R9 no busy after abort");
    do_read(6'd7, 16'hFFFF, "R9 cell unchanged", 0);

    // R6: write all
    do_ext(2'b01, 16'h1234, DW);
    wait_ready("R6 busy then ready");
    do_read(6'd0, 16'h1234, "R6 first cell", 0);
    do_read(6'd63, 16'h1234, "R6 last cell", 0);
    do_read(6'd5, 16'h1234, "R6 overwrites", 0);

    // R5: disable again, write and write-all dropped
    do_ext(2'b00, '0, 0);
    do_write(6'd3, 16'hBEEF);
    expect_idle("R5 disabled write");
    do_ext(2'b01, 16'h0F0F, DW);
    expect_idle("R5 disabled write-all");
    do_read(6'd3, 16'h1234, "R10 read disabled", 0);

    repeat (5) @(negedge clk);
    check(exp_q.size() == 0, "SCOREBOARD drained", exp_q.size(), 32'h0);
    finish_run();
  end
endmodule